// File: doc/BRIEF.md
# Sticky Link Error Status Register

This block holds a 32-bit error and diagnostic status word for one port of a serial storage link. Single-cycle event strobes from the physical, link and transport layers are qualified and then latched into sticky bits. A bit stays set until software clears it by writing a one to its position. A global reset or a port reset also clears it.

Two events are qualified before they reach the register. An unknown-type frame that arrived with a good checksum goes to one of two bits, chosen by its length. A symbol decode error counts only when it falls on a frame data word. The disparity bit never sets. Out-of-band connect detection and any change in the PHY-ready level are also sent out as registered one-cycle pulses, which feed a separate interrupt status register.

Top module: `lnk_err_sticky`

## Requirements
- R1: A set status bit keeps the value 1 on every following cycle until a write clears it or a reset occurs.
- R2: A write with `reg_sel`=1 and `reg_we`=1 clears exactly the bits where `reg_wdata` holds 1. Bits written with 0 keep their value, and a write never sets a bit.
- R3: If a bit's set event and a write clearing that bit occur in the same cycle, the bit ends up as 1.
- R4: `rst` (global) or `port_rst` (port reset), when sampled high, clears the whole register and both pulse outputs. One cycle later a read returns 0.
- R5: Bits 31:27, 15:12, 7:2 and bit 20 (disparity) always read as 0.
- R6: `ev_cominit` sets bit 26. It also drives `irq_conn_change` high for the cycle after the event.
- R7: An `ev_unk_frame` whose `unk_len` is at most UNK_MAX_LEN (64) sets bit 25. A longer one sets bit 24 and leaves bit 25 unchanged.
- R8: `ev_decode_err` sets bit 19 only when `decode_on_data`=1. A decode error with `decode_on_data`=0 (a primitive) has no effect.
- R9: A change of `phy_rdy` in either direction, measured against its value on the previous cycle, sets bit 16. It also drives `irq_rdy_change` high for one cycle after the change.
- R10: The remaining sources set these bits: `ev_transport_err` sets bit 24, `ev_link_seq_err` sets 23, `ev_rx_nak` sets 22, `ev_rx_crc_err` sets 21, `ev_comwake` sets 18, `ev_phy_int_err` sets 17, `ev_misc_err[5:2]` sets 11:8, and `ev_misc_err[1:0]` sets 1:0.
- R11: `reg_rdata` is registered. A read (`reg_sel`=1, `reg_we`=0) returns, one cycle later, the register value as it stood before that clock edge. In every other cycle `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Global synchronous reset, active high |
| port_rst | input | 1 | Port reset, clears the register |
| reg_sel | input | 1 | Register select from address decode |
| reg_we | input | 1 | Write enable (1 = write, 0 = read) |
| reg_wdata | input | 32 | Write data, 1 = clear that bit |
| reg_rdata | output | 32 | Registered read data |
| ev_cominit | input | 1 | Connect-init detected by PHY |
| ev_comwake | input | 1 | Wake signal detected by PHY |
| ev_phy_int_err | input | 1 | PHY internal error |
| phy_rdy | input | 1 | PHY ready level |
| ev_link_seq_err | input | 1 | Link state machine error |
| ev_rx_nak | input | 1 | Negative handshake received for a sent frame |
| ev_rx_crc_err | input | 1 | Link CRC error on reception |
| ev_transport_err | input | 1 | Transport protocol violation |
| ev_unk_frame | input | 1 | Unknown frame type with good CRC |
| unk_len | input | LEN_W | Length in bytes of that unknown frame |
| ev_decode_err | input | 1 | Symbol decode error |
| decode_on_data | input | 1 | Decode error fell on a frame data word |
| ev_misc_err | input | 6 | Low error group sources |
| irq_conn_change | output | 1 | Connect-change pulse to interrupt status |
| irq_rdy_change | output | 1 | PHY-ready-change pulse to interrupt status |

## Verification
A wrong bit inside this block shows at the ports only on a read, which returns the register one cycle later. For that reason the bench reads after every stimulus group, and a lost set, a missing clear or a bit set by mistake appears in the next read. The qualification paths are driven with inputs on both sides of each boundary: frame length 64 against 65, and a decode error on data against one on a primitive. The two pulse outputs are compared with a reference model on every cycle, so a wrong edge detector appears one cycle after the `phy_rdy` transition.

// File: rtl/lnk_err_pkg.sv
package lnk_err_pkg;
  localparam int REG_W = 32;
  localparam int MISC_W = 6;

  // bit positions decoded by software
  localparam int B_XCHG     = 26;
  localparam int B_UNK_FIS  = 25;
  localparam int B_TRANSP   = 24;
  localparam int B_LINK_SEQ = 23;
  localparam int B_NAK      = 22;
  localparam int B_CRC      = 21;
  localparam int B_DISP     = 20;
  localparam int B_DECODE   = 19;
  localparam int B_WAKE     = 18;
  localparam int B_PHY_INT  = 17;
  localparam int B_RDY_CHG  = 16;

  // implemented (sticky) positions; all others read zero
  localparam logic [REG_W-1:0] IMPL_MASK = 32'h07EF_0F03;
endpackage

// File: rtl/lnk_err_qual.sv
module lnk_err_qual
  import lnk_err_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int UNK_MAX_LEN = 64
) (
  input  logic              clk,
  input  logic              ev_cominit,
  input  logic              ev_comwake,
  input  logic              ev_phy_int_err,
  input  logic              phy_rdy,
  input  logic              ev_link_seq_err,
  input  logic              ev_rx_nak,
  input  logic              ev_rx_crc_err,
  input  logic              ev_transport_err,
  input  logic              ev_unk_frame,
  input  logic [LEN_W-1:0]  unk_len,
  input  logic              ev_decode_err,
  input  logic              decode_on_data,
  input  logic [MISC_W-1:0] ev_misc_err,
  output logic [REG_W-1:0]  set_vec,
  output logic              rdy_chg
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(UNK_MAX_LEN);

  logic phy_rdy_q;
  logic unk_short, unk_long;

  // tracks the level through reset so no spurious change follows release
  always_ff @(posedge clk) phy_rdy_q <= phy_rdy;

  assign rdy_chg   = phy_rdy ^ phy_rdy_q;
  assign unk_short = ev_unk_frame && (unk_len <= MAX_LEN);
  assign unk_long  = ev_unk_frame && (unk_len >  MAX_LEN);

  always_comb begin
    set_vec              = '0;
    set_vec[B_XCHG]      = ev_cominit;
    set_vec[B_UNK_FIS]   = unk_short;
    set_vec[B_TRANSP]    = ev_transport_err | unk_long;
    set_vec[B_LINK_SEQ]  = ev_link_seq_err;
    set_vec[B_NAK]       = ev_rx_nak;
    set_vec[B_CRC]       = ev_rx_crc_err;
    set_vec[B_DECODE]    = ev_decode_err & decode_on_data;
    set_vec[B_WAKE]      = ev_comwake;
    set_vec[B_PHY_INT]   = ev_phy_int_err;
    set_vec[B_RDY_CHG]   = rdy_chg;
    set_vec[11:8]        = ev_misc_err[5:2];
    set_vec[1:0]         = ev_misc_err[1:0];
  end
endmodule

// File: rtl/lnk_err_cell.sv
module lnk_err_cell (
  input  logic clk,
  input  logic clr_all,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (clr_all)  q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R3: an event in a clearing cycle is kept
  a_r3_set_wins: assert property (@(posedge clk) disable iff (clr_all)
    (set && clr) |=> q);

  // R1: without clear or reset a set bit holds
  a_r1_sticky_hold: assert property (@(posedge clk) disable iff (clr_all)
    (q && !clr) |=> q);
endmodule

// File: rtl/lnk_err_sticky.sv
module lnk_err_sticky
  import lnk_err_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int UNK_MAX_LEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_rst,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ev_cominit,
  input  logic              ev_comwake,
  input  logic              ev_phy_int_err,
  input  logic              phy_rdy,
  input  logic              ev_link_seq_err,
  input  logic              ev_rx_nak,
  input  logic              ev_rx_crc_err,
  input  logic              ev_transport_err,
  input  logic              ev_unk_frame,
  input  logic [LEN_W-1:0]  unk_len,
  input  logic              ev_decode_err,
  input  logic              decode_on_data,
  input  logic [5:0]        ev_misc_err,
  output logic              irq_conn_change,
  output logic              irq_rdy_change
);
  logic             clr_all;
  logic             wr_hit, rd_hit;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] status;
  logic             rdy_chg;

  assign clr_all = rst | port_rst;
  assign wr_hit  = reg_sel &  reg_we;
  assign rd_hit  = reg_sel & ~reg_we;

  lnk_err_qual #(.LEN_W(LEN_W), .UNK_MAX_LEN(UNK_MAX_LEN)) u_qual (
    .clk              (clk),
    .ev_cominit       (ev_cominit),
    .ev_comwake       (ev_comwake),
    .ev_phy_int_err   (ev_phy_int_err),
    .phy_rdy          (phy_rdy),
    .ev_link_seq_err  (ev_link_seq_err),
    .ev_rx_nak        (ev_rx_nak),
    .ev_rx_crc_err    (ev_rx_crc_err),
    .ev_transport_err (ev_transport_err),
    .ev_unk_frame     (ev_unk_frame),
    .unk_len          (unk_len),
    .ev_decode_err    (ev_decode_err),
    .decode_on_data   (decode_on_data),
    .ev_misc_err      (ev_misc_err),
    .set_vec          (set_vec),
    .rdy_chg          (rdy_chg)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_cell
      lnk_err_cell u_cell (
        .clk     (clk),
        .clr_all (clr_all),
        .set     (set_vec[i]),
        .clr     (wr_hit & reg_wdata[i]),
        .q       (status[i])
      );
    end else begin : g_tie
      assign status[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_all) begin
      reg_rdata       <= '0;
      irq_conn_change <= 1'b0;
      irq_rdy_change  <= 1'b0;
    end else begin
      reg_rdata       <= rd_hit ? status : '0;
      irq_conn_change <= ev_cominit;
      irq_rdy_change  <= rdy_chg;
    end
  end

  // R4: reset empties register and pulses
  a_r4_reset_clears: assert property (@(posedge clk)
    clr_all |=> (status == '0 && !irq_conn_change && !irq_rdy_change));

  // R5: reserved and disparity positions never show
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ((reg_rdata & ~IMPL_MASK) == '0) && !reg_rdata[B_DISP]);

  // R6: connect detect latched and forwarded
  a_r6_cominit: assert property (@(posedge clk) disable iff (clr_all)
    ev_cominit |=> (irq_conn_change && status[B_XCHG]));

  // R9: a ready-level change is latched and forwarded
  a_r9_rdy_change: assert property (@(posedge clk) disable iff (clr_all)
    (phy_rdy != $past(phy_rdy)) |=> (irq_rdy_change && status[B_RDY_CHG]));

  // R11: no data on non-read cycles
  a_r11_idle_rdata: assert property (@(posedge clk) disable iff (clr_all)
    !rd_hit |=> (reg_rdata == '0));
endmodule

// File: tb/lnk_err_sticky_test.sv
module lnk_err_sticky_test;
  localparam logic [31:0] MASK = 32'h07EF_0F03;

  logic        clk = 1'b0;
  logic        rst = 1'b1, port_rst = 1'b0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_cominit = 0, ev_comwake = 0, ev_phy_int_err = 0, phy_rdy = 0;
  logic        ev_link_seq_err = 0, ev_rx_nak = 0, ev_rx_crc_err = 0;
  logic        ev_transport_err = 0, ev_unk_frame = 0;
  logic [15:0] unk_len = '0;
  logic        ev_decode_err = 0, decode_on_data = 0;
  logic [5:0]  ev_misc_err = '0;
  logic        irq_conn_change, irq_rdy_change;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  lnk_err_sticky uut (
    .clk(clk), .rst(rst), .port_rst(port_rst),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_cominit(ev_cominit), .ev_comwake(ev_comwake), .ev_phy_int_err(ev_phy_int_err),
    .phy_rdy(phy_rdy), .ev_link_seq_err(ev_link_seq_err), .ev_rx_nak(ev_rx_nak),
    .ev_rx_crc_err(ev_rx_crc_err), .ev_transport_err(ev_transport_err),
    .ev_unk_frame(ev_unk_frame), .unk_len(unk_len), .ev_decode_err(ev_decode_err),
    .decode_on_data(decode_on_data), .ev_misc_err(ev_misc_err),
    .irq_conn_change(irq_conn_change), .irq_rdy_change(irq_rdy_change)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // behavioural reference, updated at each rising edge
  logic [31:0] m_st = '0, m_rd = '0;
  logic        m_irqc = 0, m_irqr = 0, m_rdy_prev = 0;
  bit          m_live = 0;

  always @(posedge clk) begin
    logic [31:0] setv, nrd;
    setv = '0;
    setv[26] = ev_cominit;
    if (ev_unk_frame) begin
      if (unk_len <= 16'd64) setv[25] = 1'b1; else setv[24] = 1'b1;
    end
    if (ev_transport_err) setv[24] = 1'b1;
    setv[23] = ev_link_seq_err;
    setv[22] = ev_rx_nak;
    setv[21] = ev_rx_crc_err;
    setv[19] = ev_decode_err && decode_on_data;
    setv[18] = ev_comwake;
    setv[17] = ev_phy_int_err;
    setv[16] = (phy_rdy != m_rdy_prev);
    setv[11:8] = ev_misc_err[5:2];
    setv[1:0]  = ev_misc_err[1:0];
    nrd = (reg_sel && !reg_we) ? m_st : 32'h0;
    if (rst || port_rst) begin
      m_st = '0; m_rd = '0; m_irqc = 0; m_irqr = 0;
    end else begin
      m_irqc = ev_cominit;
      m_irqr = setv[16];
      m_rd   = nrd;
      if (reg_sel && reg_we) m_st = m_st & ~reg_wdata;
      m_st = (m_st | setv) & MASK;
    end
    m_rdy_prev = phy_rdy;
    if (!rst) m_live = 1;
  end

  always @(negedge clk) begin
    if (m_live && !done) begin
      check("R11 model rdata", reg_rdata, m_rd);
      check("R6 model irq_conn_change", {31'b0, irq_conn_change}, {31'b0, m_irqc});
      check("R9 model irq_rdy_change", {31'b0, irq_rdy_change}, {31'b0, m_irqr});
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); reg_sel = 1; reg_we = 1; reg_wdata = d;
    @(negedge clk); reg_sel = 0; reg_we = 0; reg_wdata = '0;
  endtask

  task automatic rd_check(string tag, logic [31:0] exp);
    @(negedge clk); reg_sel = 1; reg_we = 0;
    @(negedge clk); reg_sel = 0;
    check(tag, reg_rdata, exp);
  endtask

  task automatic clear_evts();
    ev_cominit = 0; ev_comwake = 0; ev_phy_int_err = 0; ev_link_seq_err = 0;
    ev_rx_nak = 0; ev_rx_crc_err = 0; ev_transport_err = 0; ev_unk_frame = 0;
    ev_decode_err = 0; decode_on_data = 0; ev_misc_err = '0;
  endtask

  initial begin
    idle(5);
    rst = 0;
    rd_check("R4 reset state", 32'h0);

    // R6 connect detect
    @(negedge clk); ev_cominit = 1;
    @(negedge clk); ev_cominit = 0;
    check("R6 irq_conn_change pulse", {31'b0, irq_conn_change}, 32'h1);
    rd_check("R6 bit 26", 32'h0400_0000);
    wr(32'h0400_0000);
    rd_check("R2 cleared bit 26", 32'h0);

    // R7 length boundary
    @(negedge clk); ev_unk_frame = 1; unk_len = 16'd64;
    @(negedge clk); clear_evts();
    rd_check("R7 len 64 sets bit 25", 32'h0200_0000);
    wr(32'hFFFF_FFFF);
    @(negedge clk); ev_unk_frame = 1; unk_len = 16'd65;
    @(negedge clk); clear_evts();
    rd_check("R7 len 65 sets bit 24 only", 32'h0100_0000);
    wr(32'hFFFF_FFFF);

    // R8 decode qualification
    @(negedge clk); ev_decode_err = 1; decode_on_data = 0;
    @(negedge clk); clear_evts();
    rd_check("R8 primitive ignored", 32'h0);
    @(negedge clk); ev_decode_err = 1; decode_on_data = 1;
    @(negedge clk); clear_evts();
    rd_check("R8 data word sets bit 19", 32'h0008_0000);
    wr(32'hFFFF_FFFF);

    // R9 both directions
    @(negedge clk); phy_rdy = 1;
    @(negedge clk);
    check("R9 rise pulse", {31'b0, irq_rdy_change}, 32'h1);
    rd_check("R9 rise sets bit 16", 32'h0001_0000);
    wr(32'h0001_0000);
    rd_check("R9 steady level no set", 32'h0);
    @(negedge clk); phy_rdy = 0;
    rd_check("R9 fall sets bit 16", 32'h0001_0000);
    wr(32'hFFFF_FFFF);

    // R10 remaining sources together
    @(negedge clk);
    ev_transport_err = 1; ev_link_seq_err = 1; ev_rx_nak = 1; ev_rx_crc_err = 1;
    ev_comwake = 1; ev_phy_int_err = 1; ev_misc_err = 6'h3F;
    @(negedge clk); clear_evts();
    rd_check("R10 source map", 32'h01E6_0F03);

    // R2 partial clear, zero write
    wr(32'h0080_0000);
    rd_check("R2 clear bit 23 only", 32'h0166_0F03);
    wr(32'h0);
    rd_check("R2 zero write no change", 32'h0166_0F03);

    // R1 holds over idle time
    idle(20);
    rd_check("R1 sticky hold", 32'h0166_0F03);

    // R11 no read -> zero output
    idle(2);
    check("R11 rdata zero when idle", reg_rdata, 32'h0);

    // R5 all-ones write cannot set reserved bits
    wr(32'hFFFF_FFFF);
    rd_check("R5 reserved stay zero", 32'h0);

    // R3 set wins over same-cycle clear
    @(negedge clk); ev_rx_crc_err = 1; reg_sel = 1; reg_we = 1; reg_wdata = 32'h0020_0000;
    @(negedge clk); clear_evts(); reg_sel = 0; reg_we = 0; reg_wdata = '0;
    rd_check("R3 set wins", 32'h0020_0000);

    // R4 port reset clears
    @(negedge clk); port_rst = 1;
    @(negedge clk); port_rst = 0;
    rd_check("R4 port reset clears", 32'h0);

    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule